// File: doc/BRIEF.md
# Hot-Swap Bus Join Sequencer

This block decides when a plug-in card's two-wire serial bus (data and clock) may be tied to a backplane bus that is already running. It watches two supply monitors, one for each side, and the sampled logic levels of the four bus lines. It drives three enables for the analog front end: a weak precharge of the lines, the bidirectional connection itself, and the rise-time accelerators.

After both supplies are good, the sequencer waits out an initialization interval with precharge active. It then looks for a quiet moment on the bus before it joins the two sides. A quiet moment is either an unbroken stretch with all four lines high, or a stop condition on the backplane pair seen while all four lines are high. Once joined, the sequencer stays joined until a supply drops, and any supply drop sends it back to the lockout state. All inputs pass through synchronizers. The intervals are given in cycles of the free-running clock.

Top module: `hotswap_join_seq`

## Requirements
- R1: The sequencer leaves lockout only when both supply rise flags are high, and the two supplies may come up in either order. A single good supply keeps every output low.
- R2: In any state other than lockout, a low supply fall flag on either side returns the sequencer to lockout. This happens 3 clock edges after the flag changes: 2 for synchronization and 1 for the state register.
- R3: In lockout, `precharge_en`, `connect_en` and `accel_en` are all 0. Lockout is also the state after reset.
- R4: Leaving lockout starts initialization. Initialization lasts exactly INIT_CYCLES cycles with `precharge_en`=1 and `connect_en`=0, and neither idle nor stop detection acts during it.
- R5: After initialization, precharge stays on. The buses join when all four lines have been high for IDLE_CYCLES consecutive synchronized samples.
- R6: After initialization, the buses join in the cycle after a backplane data rise (synchronized sample 0 then 1) is seen while all four lines are high, with no idle wait. A data rise that happens while the backplane clock is low does not join.
- R7: Any of the four lines going low during the idle wait restarts the idle count from zero. A full IDLE_CYCLES interval is then needed again.
- R8: While joined: `connect_en`=1 and `precharge_en`=0. `accel_en` equals the synchronized accelerator-enable pin, where 1 means enabled. The sequencer stays joined until a supply drop (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_a_rise_ok | input | 1 | Side A supply is above its rising threshold |
| sup_a_fall_ok | input | 1 | Side A supply is above its falling threshold (0 = dropped) |
| sup_b_rise_ok | input | 1 | Side B supply is above its rising threshold |
| sup_b_fall_ok | input | 1 | Side B supply is above its falling threshold (0 = dropped) |
| bp_sda | input | 1 | Sampled backplane data line |
| bp_scl | input | 1 | Sampled backplane clock line |
| cd_sda | input | 1 | Sampled card data line |
| cd_scl | input | 1 | Sampled card clock line |
| accel_pin | input | 1 | Accelerator enable strap (1 = allow) |
| precharge_en | output | 1 | Enables line precharge |
| connect_en | output | 1 | Joins backplane and card buses |
| accel_en | output | 1 | Enables the rise-time accelerators |

## Verification
Some rules hold on every cycle, and the assertions check those: the outputs are quiet in lockout, a supply drop forces lockout, a join only starts from detection with all lines high, and precharge and accelerators are consistent with the joined state. The timers may never pass their limits. Other behaviour can only be shown by the bench scenarios, which compare every cycle against a behavioural model. These are the exact lengths of initialization and of the idle wait, the restart of the idle count after a glitch, the immediate join on a backplane stop, a data rise under a low clock that must not join, and the supplies arriving in either order.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [1:0] {
      ST_LOCK   = 2'd0,
      ST_INIT   = 2'd1,
      ST_DETECT = 2'd2,
      ST_JOINED = 2'd3
   } join_state_t;

   // bit positions inside the synchronized input vector
   localparam int unsigned IX_A_RISE = 0;
   localparam int unsigned IX_B_RISE = 1;
   localparam int unsigned IX_A_FALL = 2;
   localparam int unsigned IX_B_FALL = 3;
   localparam int unsigned IX_BP_SDA = 4;
   localparam int unsigned IX_BP_SCL = 5;
   localparam int unsigned IX_CD_SDA = 6;
   localparam int unsigned IX_CD_SCL = 7;
   localparam int unsigned IX_ACCEL  = 8;
   localparam int unsigned IN_WIDTH  = 9;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hs_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_cycle_timer.sv
module hs_cycle_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic done
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("hs_cycle_timer: LIMIT must be at least 2");
   end

   localparam int unsigned CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clear)         cnt_q <= '0;
      else if (run && !done)  cnt_q <= cnt_q + CW'(1);
   end

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);                                             // R4
   AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));                                   // R7
endmodule

// File: rtl/hs_stop_detect.sv
module hs_stop_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_s,
   input  logic scl_s,
   input  logic lines_high,
   output logic stop_seen
);
   logic sda_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_prev_q <= 1'b0;
      else        sda_prev_q <= sda_s;
   end

   assign stop_seen = lines_high && scl_s && sda_s && !sda_prev_q;

   AST_STOP_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> $past(sda_s) && $past(scl_s));                // R6
endmodule

// File: rtl/hs_join_fsm.sv
module hs_join_fsm
   import hs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        both_rise,
   input  logic        supply_drop,
   input  logic        init_done,
   input  logic        idle_done,
   input  logic        stop_seen,
   output join_state_t state_o
);
   join_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (state_q != ST_LOCK && supply_drop) begin
         state_d = ST_LOCK;
      end else begin
         unique case (state_q)
            ST_LOCK:   if (both_rise)              state_d = ST_INIT;
            ST_INIT:   if (init_done)              state_d = ST_DETECT;
            ST_DETECT: if (stop_seen || idle_done) state_d = ST_JOINED;
            ST_JOINED: state_d = ST_JOINED;
            default:   state_d = ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOCK;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   AST_LOCK_EXIT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK && !both_rise) |=> state_q == ST_LOCK); // R1
   AST_INIT_TO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INIT && !supply_drop && !init_done) |=> state_q == ST_INIT); // R4
endmodule

// File: rtl/hotswap_join_seq.sv
module hotswap_join_seq
   import hs_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 36000,
   parameter int unsigned IDLE_CYCLES = 28000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_a_rise_ok,
   input  logic sup_a_fall_ok,
   input  logic sup_b_rise_ok,
   input  logic sup_b_fall_ok,
   input  logic bp_sda,
   input  logic bp_scl,
   input  logic cd_sda,
   input  logic cd_scl,
   input  logic accel_pin,
   output logic precharge_en,
   output logic connect_en,
   output logic accel_en
);
   if (INIT_CYCLES < 2 || IDLE_CYCLES < 2) begin : g_bad_times
      $error("hotswap_join_seq: interval parameters must be at least 2");
   end

   logic [IN_WIDTH-1:0] raw_vec, syn_vec;
   logic both_rise, supply_drop, lines_high;
   logic init_done, idle_done, stop_seen;
   join_state_t state;

   assign raw_vec[IX_A_RISE] = sup_a_rise_ok;
   assign raw_vec[IX_B_RISE] = sup_b_rise_ok;
   assign raw_vec[IX_A_FALL] = sup_a_fall_ok;
   assign raw_vec[IX_B_FALL] = sup_b_fall_ok;
   assign raw_vec[IX_BP_SDA] = bp_sda;
   assign raw_vec[IX_BP_SCL] = bp_scl;
   assign raw_vec[IX_CD_SDA] = cd_sda;
   assign raw_vec[IX_CD_SCL] = cd_scl;
   assign raw_vec[IX_ACCEL]  = accel_pin;

   hs_sync #(.WIDTH(IN_WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw_vec), .sync_o(syn_vec));

   assign both_rise   = syn_vec[IX_A_RISE] && syn_vec[IX_B_RISE];
   assign supply_drop = !syn_vec[IX_A_FALL] || !syn_vec[IX_B_FALL];
   assign lines_high  = syn_vec[IX_BP_SDA] && syn_vec[IX_BP_SCL] &&
                        syn_vec[IX_CD_SDA] && syn_vec[IX_CD_SCL];

   hs_cycle_timer #(.LIMIT(INIT_CYCLES)) u_init_timer (
      .clk(clk), .rst_n(rst_n),
      .clear(state != ST_INIT),
      .run(state == ST_INIT),
      .done(init_done));

   hs_cycle_timer #(.LIMIT(IDLE_CYCLES)) u_idle_timer (
      .clk(clk), .rst_n(rst_n),
      .clear(state != ST_DETECT || !lines_high),
      .run(state == ST_DETECT && lines_high),
      .done(idle_done));

   hs_stop_detect u_stop (
      .clk(clk), .rst_n(rst_n),
      .sda_s(syn_vec[IX_BP_SDA]), .scl_s(syn_vec[IX_BP_SCL]),
      .lines_high(lines_high), .stop_seen(stop_seen));

   hs_join_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .both_rise(both_rise), .supply_drop(supply_drop),
      .init_done(init_done), .idle_done(idle_done),
      .stop_seen(stop_seen), .state_o(state));

   assign precharge_en = (state == ST_INIT) || (state == ST_DETECT);
   assign connect_en   = (state == ST_JOINED);
   assign accel_en     = connect_en && syn_vec[IX_ACCEL];

   AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_LOCK |-> !(precharge_en || connect_en || accel_en)); // R3
   AST_DROP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_LOCK && supply_drop) |=> state == ST_LOCK);    // R2
   AST_JOIN_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connect_en) |-> $past(lines_high));                   // R5
   AST_JOIN_FROM_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connect_en) |-> $past(state) == ST_DETECT);           // R4
   AST_JOINED_NO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      connect_en |-> !precharge_en);                              // R8
   AST_STAYS_JOINED: assert property (@(posedge clk) disable iff (!rst_n)
      (connect_en && !supply_drop) |=> connect_en);               // R8
   AST_ACCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      accel_en |-> connect_en);                                   // R8
endmodule

// File: tb/hotswap_join_seq_tb.sv
`timescale 1ns/1ps
module hotswap_join_seq_tb;
   localparam int INIT_N = 20;
   localparam int IDLE_N = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ra = 0, rb = 0, fa = 0, fb = 0;
   logic bsda = 1, bscl = 1, csda = 1, cscl = 1, acc = 1;
   logic pre_o, con_o, acc_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   hotswap_join_seq #(.INIT_CYCLES(INIT_N), .IDLE_CYCLES(IDLE_N), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sup_a_rise_ok(ra), .sup_a_fall_ok(fa),
      .sup_b_rise_ok(rb), .sup_b_fall_ok(fb),
      .bp_sda(bsda), .bp_scl(bscl), .cd_sda(csda), .cd_scl(cscl),
      .accel_pin(acc),
      .precharge_en(pre_o), .connect_en(con_o), .accel_en(acc_o));

   // behavioural reference: input delay queue, mode number, integer counters
   logic [8:0] dq[$];
   int m_mode = 0;   // 0 lockout, 1 init, 2 watch, 3 joined
   int m_init = 0;
   int m_idle = 0;
   bit m_prev = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq = {9'd0, 9'd0};
         m_mode = 0; m_init = 0; m_idle = 0; m_prev = 0;
      end else begin
         logic [8:0] s;
         bit allh;
         s = dq[0];
         allh = s[4] && s[5] && s[6] && s[7];
         if (m_mode != 0 && (!s[2] || !s[3])) begin
            m_mode = 0; m_init = 0; m_idle = 0;
         end else if (m_mode == 0) begin
            if (s[0] && s[1]) begin m_mode = 1; m_init = 0; end
         end else if (m_mode == 1) begin
            if (m_init == INIT_N - 1) begin m_mode = 2; m_idle = 0; end
            else m_init++;
         end else if (m_mode == 2) begin
            if (allh && s[4] && !m_prev) m_mode = 3;
            else if (!allh) m_idle = 0;
            else if (m_idle == IDLE_N - 1) m_mode = 3;
            else m_idle++;
         end
         m_prev = s[4];
         void'(dq.pop_front());
         dq.push_back({acc, cscl, csda, bscl, bsda, fb, fa, rb, ra});
      end
   end

   task automatic chk(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         string tag;
         logic e_pre, e_con, e_acc;
         tag = (m_mode == 0) ? "R3" : (m_mode == 1) ? "R4" : (m_mode == 2) ? "R5" : "R8";
         e_pre = (m_mode == 1 || m_mode == 2);
         e_con = (m_mode == 3);
         e_acc = e_con && dq[0][8];
         chk(tag, pre_o, e_pre, "model precharge_en");
         chk(tag, con_o, e_con, "model connect_en");
         chk(tag, acc_o, e_acc, "model accel_en");
      end
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(4);
      chk("R3", pre_o, 1'b0, "reset precharge_en");
      chk("R3", con_o, 1'b0, "reset connect_en");
      chk("R3", acc_o, 1'b0, "reset accel_en");
      rst_n = 1'b1;

      // only side A up
      ra = 1; fa = 1;
      step(40);
      chk("R1", pre_o, 1'b0, "single supply precharge_en");
      chk("R1", con_o, 1'b0, "single supply connect_en");

      // side B joins, lines all high
      rb = 1; fb = 1;
      step(5);
      chk("R4", pre_o, 1'b1, "init precharge_en");
      step(10);
      chk("R4", con_o, 1'b0, "init connect_en");
      step(60);
      chk("R5", con_o, 1'b1, "idle join connect_en");
      chk("R8", pre_o, 1'b0, "joined precharge_en");
      chk("R8", acc_o, 1'b1, "joined accel_en");
      acc = 0; step(4);
      chk("R8", acc_o, 1'b0, "accel pin low");
      acc = 1; step(4);

      // supply A drops
      fa = 0; ra = 0;
      step(4);
      chk("R2", con_o, 1'b0, "drop connect_en");
      chk("R2", pre_o, 1'b0, "drop precharge_en");

      // A returns second (B already up), card data held low
      csda = 0;
      ra = 1; fa = 1;
      step(4);
      chk("R1", pre_o, 1'b1, "B-first precharge_en");
      step(70);
      chk("R5", con_o, 1'b0, "busy line connect_en");
      csda = 1; step(20);
      csda = 0; step(1);
      csda = 1; step(20);
      chk("R7", con_o, 1'b0, "glitch restarts idle");
      step(15);
      chk("R5", con_o, 1'b1, "join after full idle");

      // B drops, then drops again during init
      fb = 0; rb = 0; step(4);
      chk("R2", con_o, 1'b0, "drop from joined");
      rb = 1; fb = 1; step(10);
      chk("R4", pre_o, 1'b1, "second init precharge_en");
      fb = 0; rb = 0; step(4);
      chk("R2", pre_o, 1'b0, "drop during init");

      // stop condition path with accelerators strapped off
      acc = 0; bsda = 0;
      rb = 1; fb = 1;
      step(40);
      chk("R6", con_o, 1'b0, "busy before stop");
      bscl = 0; step(2);
      bsda = 1; step(2);
      bscl = 1; step(6);
      chk("R6", con_o, 1'b0, "data rise under low clock");
      bsda = 0; step(3);
      bsda = 1; step(4);
      chk("R6", con_o, 1'b1, "stop join connect_en");
      chk("R8", acc_o, 1'b0, "accel strapped off");
      step(10);
      chk("R8", con_o, 1'b1, "remains joined");

      step(5);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule